// File: doc/BRIEF.md
# Fixed-Point Add/Subtract Unit

A purely combinational integer adder for the execute stage of a RISC core. One 64-bit carry-propagate adder serves every add and subtract form. An operation code chooses three things: the first addend (the RA value, zero, the inverted RA value, or the next instruction address), the second addend (RB, a sign-extended immediate, the immediate shifted up by 16, all ones, or zero), and the carry-in (0, 1, the stored carry flag, or the stored overflow flag).

Subtraction is always formed as "subtract from": the inverted first operand plus the second operand plus one. The result comes out with the carry out of the top bit, a signed-overflow indication and, when the record input is set, a four-bit condition field. Register reads, decode and flag storage sit outside the block. The flags it produces are only candidates, which the surrounding pipeline commits or discards.

Top module: `fxu_addsub`

## Requirements
- R1: Op 0 gives ra+rb. Op 1 gives base+sext(imm). Op 2 gives base+sext({imm,16'h0}). For ops 1 and 2 the base is 0 when ra_is_zero=1 and ra otherwise. Op 0 ignores ra_is_zero.
- R2: For op 2 the 16-bit immediate gets 16 zero bits appended below it, and the 32-bit value is then sign-extended to 64 bits.
- R3: Op 3 gives nia+sext({imm,16'h0}), with ra and ra_is_zero having no effect.
- R4: Op 4 gives ~ra+rb+1 and op 5 gives ~ra+sext(imm)+1.
- R5: Op 6 gives ra+rb+ca_in and op 7 gives ~ra+rb+ca_in.
- R6: Op 8 gives ra+all-ones+ca_in, op 9 gives ~ra+all-ones+ca_in, op 10 gives ra+ca_in and op 11 gives ~ra+ca_in.
- R7: Op 13 gives ra+rb+ov_in, so ca_in has no effect on it.
- R8: Op 12 gives ~ra+1, the two's complement negation.
- R9: ca_out is bit 64 of the 65-bit sum of the two selected addends and the carry-in.
- R10: ov_out is 1 exactly when the two selected addends have equal sign bits and the sign bit of rt differs from them.
- R11: With rec=1, cr0 = {rt negative, rt positive, rt zero, so_in}, where exactly one of bits 3..1 is set. With rec=0, cr0 is 4'b0000.
- R12: Op codes 14 and 15 behave as op 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ra | input | 64 | First register operand |
| rb | input | 64 | Second register operand |
| imm | input | 16 | Immediate field |
| ra_is_zero | input | 1 | Register field of ra is 0 (immediate adds use zero) |
| nia | input | 64 | Next instruction address |
| ca_in | input | 1 | Stored carry flag |
| ov_in | input | 1 | Stored overflow flag (alternate carry) |
| so_in | input | 1 | Stored summary-overflow flag |
| op | input | 4 | Operation code |
| rec | input | 1 | Record enable for cr0 |
| rt | output | 64 | Result |
| ca_out | output | 1 | Carry out of the top bit |
| ov_out | output | 1 | Signed overflow |
| cr0 | output | 4 | {negative, positive, zero, summary overflow} |

## Verification
Every operation code is driven with operands taken from 0, all ones, the most negative value, the most positive value and random values. These corner values are the ones that separate a carry-out from a signed overflow, and that catch a wrong inversion or a dropped carry-in. ca_in, ov_in and ra_is_zero are toggled on operations that must ignore them, which shows that each operation picks its carry-in source and its base operand correctly. Immediates with the top bit set, and with it clear, check the sign extension both unshifted and shifted.

// File: rtl/fxu_addsub.sv
module fxu_addsub #(
  parameter int W  = 64,
  parameter int IW = 16
) (
  input  logic [W-1:0]  ra,
  input  logic [W-1:0]  rb,
  input  logic [IW-1:0] imm,
  input  logic          ra_is_zero,
  input  logic [W-1:0]  nia,
  input  logic          ca_in,
  input  logic          ov_in,
  input  logic          so_in,
  input  logic [3:0]    op,
  input  logic          rec,
  output logic [W-1:0]  rt,
  output logic          ca_out,
  output logic          ov_out,
  output logic [3:0]    cr0
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADDI = 4'd1, OP_ADDIS = 4'd2, OP_ADDPC = 4'd3,
                         OP_SUBF = 4'd4, OP_SUBFI = 4'd5, OP_ADDE = 4'd6, OP_SUBFE = 4'd7,
                         OP_ADDME = 4'd8, OP_SUBFME = 4'd9, OP_ADDZE = 4'd10, OP_SUBFZE = 4'd11,
                         OP_NEG = 4'd12, OP_ADDEX = 4'd13;

  logic [W-1:0] imm_x, imm_hi, base, opa, opb;
  logic         cin;

  assign imm_x  = {{(W-IW){imm[IW-1]}}, imm};
  assign imm_hi = {{(W-2*IW){imm[IW-1]}}, imm, {IW{1'b0}}};
  assign base   = ra_is_zero ? '0 : ra;

  always_comb begin
    opa = ra;
    opb = rb;
    cin = 1'b0;
    case (op)
      OP_ADDI:   opb = imm_x;
      OP_ADDIS:  opb = imm_hi;
      OP_ADDPC:  opb = imm_hi;
      OP_SUBF:   begin opa = ~ra; cin = 1'b1; end
      OP_SUBFI:  begin opa = ~ra; opb = imm_x; cin = 1'b1; end
      OP_ADDE:   cin = ca_in;
      OP_SUBFE:  begin opa = ~ra; cin = ca_in; end
      OP_ADDME:  begin opb = '1; cin = ca_in; end
      OP_SUBFME: begin opa = ~ra; opb = '1; cin = ca_in; end
      OP_ADDZE:  begin opb = '0; cin = ca_in; end
      OP_SUBFZE: begin opa = ~ra; opb = '0; cin = ca_in; end
      OP_NEG:    begin opa = ~ra; opb = '0; cin = 1'b1; end
      OP_ADDEX:  cin = ov_in;
      default:   ;
    endcase
    if (op == OP_ADDI || op == OP_ADDIS) opa = base;
    if (op == OP_ADDPC) opa = nia;
  end

  assign {ca_out, rt} = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cin};
  assign ov_out = (opa[W-1] == opb[W-1]) && (rt[W-1] != opa[W-1]);

  logic is_neg, is_zero;
  assign is_neg  = rt[W-1];
  assign is_zero = (rt == '0);
  assign cr0 = rec ? {is_neg, ~is_neg & ~is_zero, is_zero, so_in} : 4'b0000;

  always_comb begin
    if (!$isunknown({op, ra, rb, ca_in, rec})) begin
      AST_NEG_ZERO: assert (!(op == OP_NEG && ra == '0) || (rt == '0 && ca_out)); // R8
      AST_SUBF_SELF: assert (!(op == OP_SUBF && ra == rb) || (rt == '0 && ca_out && !ov_out)); // R4
      AST_ADDZE_PASS: assert (!(op == OP_ADDZE && !ca_in) || (rt == ra && !ca_out)); // R6
      AST_ADD_OVF: assert (!(op == OP_ADD && ov_out) || (ra[W-1] == rb[W-1] && rt[W-1] != ra[W-1])); // R10
      AST_CR0_ONE: assert (!rec || $countones(cr0[3:1]) == 1); // R11
    end
  end
endmodule

// File: tb/fxu_addsub_bench.sv
module fxu_addsub_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [63:0] ra, rb, nia, rt;
  logic [15:0] imm;
  logic ra_is_zero, ca_in, ov_in, so_in, rec, ca_out, ov_out;
  logic [3:0] op, cr0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  fxu_addsub u_fxu_addsub (.ra(ra), .rb(rb), .imm(imm), .ra_is_zero(ra_is_zero), .nia(nia),
    .ca_in(ca_in), .ov_in(ov_in), .so_in(so_in), .op(op), .rec(rec),
    .rt(rt), .ca_out(ca_out), .ov_out(ov_out), .cr0(cr0));

  function automatic string req_of(input logic [3:0] o);
    case (o)
      0, 1: return "R1";  2: return "R2";  3: return "R3";
      4, 5: return "R4";  6, 7: return "R5";
      8, 9, 10, 11: return "R6";  12: return "R8";  13: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic run_one;
    logic [63:0] a, b, sx, sh, r;
    logic c, v, neg, zer;
    logic [64:0] s;
    sx = {{48{imm[15]}}, imm};
    sh = {{32{imm[15]}}, imm, 16'h0};
    a = ra; b = rb; c = 1'b0;
    case (op)
      1: begin a = ra_is_zero ? 64'd0 : ra; b = sx; end
      2: begin a = ra_is_zero ? 64'd0 : ra; b = sh; end
      3: begin a = nia; b = sh; end
      4: begin a = ~ra; c = 1; end
      5: begin a = ~ra; b = sx; c = 1; end
      6: c = ca_in;
      7: begin a = ~ra; c = ca_in; end
      8: begin b = '1; c = ca_in; end
      9: begin a = ~ra; b = '1; c = ca_in; end
      10: begin b = 0; c = ca_in; end
      11: begin a = ~ra; b = 0; c = ca_in; end
      12: begin a = ~ra; b = 0; c = 1; end
      13: c = ov_in;
      default: ;
    endcase
    s = {1'b0, a} + {1'b0, b} + 65'(c);
    r = s[63:0];
    v = (a[63] == b[63]) && (r[63] != a[63]);
    neg = r[63]; zer = (r == 0);
    #2;
    check(req_of(op), "rt", rt, r);
    check("R9", "ca_out", {63'd0, ca_out}, {63'd0, s[64]});
    check("R10", "ov_out", {63'd0, ov_out}, {63'd0, v});
    check("R11", "cr0", {60'd0, cr0}, rec ? {60'd0, neg, ~neg & ~zer, zer, so_in} : 64'd0);
    #6;
  endtask

  function automatic logic [63:0] pick;
    case ($urandom % 6)
      0: return 64'd0;
      1: return '1;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'h7fff_ffff_ffff_ffff;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    void'($urandom(32'd2718));
    {ra, rb, nia, imm, ra_is_zero, ca_in, ov_in, so_in, op, rec} = '0;
    #2;
    check("R11", "idle rt", rt, 64'd0);
    check("R11", "idle cr0", {60'd0, cr0}, 64'd0);
    #6;
    // R1: ra_is_zero ignored by op 0, honoured by op 1
    ra = 64'd5; rb = 64'd7; ra_is_zero = 1; rec = 1; op = 0; run_one();
    op = 1; imm = 16'hfffe; run_one();
    // R2: negative shifted immediate
    op = 2; ra_is_zero = 0; ra = 64'd1; imm = 16'h8000; run_one();
    // R3: ra must not matter
    op = 3; nia = 64'h1000; ra = '1; imm = 16'h0001; run_one();
    // R8 most negative
    op = 12; ra = 64'h8000_0000_0000_0000; run_one();
    // R7: ca_in must not matter
    op = 13; ra = '1; rb = 0; ca_in = 1; ov_in = 0; run_one();
    ov_in = 1; ca_in = 0; run_one();
    // R12
    op = 15; ra = 64'h7fff_ffff_ffff_ffff; rb = 1; run_one();
    for (int i = 0; i < 3000; i++) begin
      ra = pick(); rb = pick(); nia = pick();
      imm = 16'($urandom); op = 4'($urandom);
      {ra_is_zero, ca_in, ov_in, so_in, rec} = 5'($urandom);
      run_one();
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule